// File: doc/BRIEF.md
# Page write-policy attribute output driver

This block produces the write-policy attribute pin that a processor bus interface shows with every bus cycle. The pin tells the outside world whether the line being accessed should be treated as writeback (0) or writethrough (1). The value is picked from one of three candidate attribute bits: the one in the page-base control register, the one in the page directory entry, and the one in the page table entry. The pick depends on the processor mode, the paging-enable control bit and the kind of access. Without paging, the value is forced to writeback.

The value is registered on the clock edge that samples the address strobe. From then on it ignores any change in its sources. A local transfer counter tracks the open bus cycle. The cycle closes on a next-address request, or on the last expected burst-ready. The last one is the 4th for a cache-line burst and the 1st for a single transfer. The pin is modelled as a value plus an output enable. The enable drops (the pin floats) on the edge that samples bus backoff, and on the edge on which the block raises hold acknowledge in response to a hold request. Hold is granted only when no bus cycle is open.

The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `page_wpol_driver`

## Requirements
- R1: When the address strobe is accepted while real mode is set or paging is disabled, the captured pin value is 0 (writeback), whatever the candidate bits are.
- R2: With paging enabled and real mode clear, access codes 0 (I/O), 1 (directory-entry fetch), 2 (other non-paged) and the unused codes 6 and 7 capture the page-base register attribute bit.
- R3: With paging enabled and real mode clear, access codes 3 (table-entry fetch) and 4 (4-Mbyte page) capture the directory-entry attribute bit.
- R4: With paging enabled and real mode clear, access code 5 (4-Kbyte page) captures the table-entry attribute bit.
- R5: An address strobe is accepted on a clock edge where the strobe is high, backoff is low and hold acknowledge is low. On that edge the pin value is loaded and the output enable goes high. On every other edge the pin value keeps its state, even if the mode, access code or candidate bits change.
- R6: On the edge that samples backoff high, the output enable goes low and any open cycle is closed. The enable stays low until the next accepted strobe.
- R7: Hold acknowledge rises on the edge after a hold request is sampled with no cycle open and no strobe present. The output enable goes low on that same edge. Acknowledge stays high while the request stays high and falls on the edge that samples the request low. Strobes are ignored while acknowledge is high.
- R8: A bus cycle stays open, and so blocks hold acknowledge, until an edge samples the next-address request high, or until the edge that samples the last expected burst-ready. The last one is the 4th burst-ready when the burst input was high at the strobe, otherwise the 1st.
- R9: While reset is asserted, and after it is released, the output enable, the pin value and hold acknowledge are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| real_mode_i | input | 1 | Processor is in real mode |
| paging_en_i | input | 1 | Paging-enable control bit |
| acc_type_i | input | 3 | Access kind code (see R2 to R4) |
| base_attr_i | input | 1 | Attribute bit of the page-base register |
| dir_attr_i | input | 1 | Attribute bit of the directory entry |
| tbl_attr_i | input | 1 | Attribute bit of the table entry |
| strobe_i | input | 1 | Address strobe, active high |
| burst_i | input | 1 | Cycle is a cache-line burst (4 transfers) |
| next_addr_i | input | 1 | Next-address request, active high |
| rdy_i | input | 1 | Burst-ready, active high |
| backoff_i | input | 1 | Bus backoff, active high |
| hold_req_i | input | 1 | Bus hold request |
| hold_ack_o | output | 1 | Bus hold acknowledge |
| pin_val_o | output | 1 | Write-policy pin value |
| pin_oe_o | output | 1 | Pin output enable, low when floated |

## Verification
The hardest case to reach from the ports is a hold request that arrives during an open burst cycle. Acknowledge must wait for exactly the 4th burst-ready or for a next-address request, and random traffic rarely produces this. Directed sequences open a burst, raise hold and spread the burst-ready pulses over idle gaps, then repeat the case with single transfers and with a next-address close. A long constrained-random run is also applied, with the candidate bits changing every cycle and backoff, hold and strobe colliding. It is checked cycle by cycle against a bench model built from the requirements.

// File: rtl/wpol_pkg.sv
package wpol_pkg;
  localparam int ACC_W = 3;

  typedef enum logic [ACC_W-1:0] {
    ACC_IO         = 3'd0,
    ACC_DIR_FETCH  = 3'd1,
    ACC_NONPAGED   = 3'd2,
    ACC_TBL_FETCH  = 3'd3,
    ACC_BIG_PAGE   = 3'd4,
    ACC_SMALL_PAGE = 3'd5
  } acc_kind_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_BASE = 2'd1,
    SRC_DIR  = 2'd2,
    SRC_TBL  = 2'd3
  } attr_src_e;
endpackage

// File: rtl/wpol_rst_sync.sv
module wpol_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpol_src_select.sv
module wpol_src_select
  import wpol_pkg::*;
(
  input  logic             real_mode_i,
  input  logic             paging_en_i,
  input  logic [ACC_W-1:0] acc_type_i,
  input  logic             base_attr_i,
  input  logic             dir_attr_i,
  input  logic             tbl_attr_i,
  output logic             sel_o
);
  attr_src_e src;

  always_comb begin
    if (real_mode_i || !paging_en_i) begin
      src = SRC_ZERO;
    end else begin
      unique case (acc_type_i)
        ACC_TBL_FETCH, ACC_BIG_PAGE: src = SRC_DIR;
        ACC_SMALL_PAGE:              src = SRC_TBL;
        default:                     src = SRC_BASE;
      endcase
    end
  end

  always_comb begin
    unique case (src)
      SRC_BASE: sel_o = base_attr_i;
      SRC_DIR:  sel_o = dir_attr_i;
      SRC_TBL:  sel_o = tbl_attr_i;
      default:  sel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wpol_xfer_track.sv
module wpol_xfer_track #(
  parameter int BURST_LEN  = 4,
  parameter int SINGLE_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic burst_i,
  input  logic abort_i,
  input  logic next_addr_i,
  input  logic rdy_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_B = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SINGLE_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (abort_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = burst_i ? LEN_B : LEN_S;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      if (next_addr_i || (rdy_i && cnt_q == CNT_W'(1))) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end else if (rdy_i) begin
        cnt_d  = cnt_q - CNT_W'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  // R8: an open cycle always has between 1 and BURST_LEN transfers left
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0 && cnt_q <= LEN_B));

  // R8: the final burst-ready closes the cycle
  p_last_rdy_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rdy_i && cnt_q == CNT_W'(1) && !start_i) |=> !busy_q);
endmodule

// File: rtl/wpol_hold_ctl.sv
module wpol_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_i,
  input  logic busy_i,
  input  logic strobe_i,
  output logic ack_o,
  output logic ack_rise_o
);
  logic ack_q, ack_d;

  always_comb begin
    ack_d      = hold_req_i && (ack_q || (!busy_i && !strobe_i));
    ack_rise_o = ack_d && !ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack_o = ack_q;

  // R7: acknowledge never survives a dropped request
  p_ack_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req_i |=> !ack_q);

  // R8: no grant while a cycle is open
  p_no_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !ack_q) |=> !ack_q);
endmodule

// File: rtl/page_wpol_driver.sv
module page_wpol_driver
  import wpol_pkg::*;
#(
  parameter int BURST_LEN   = 4,
  parameter int SINGLE_LEN  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             real_mode_i,
  input  logic             paging_en_i,
  input  logic [ACC_W-1:0] acc_type_i,
  input  logic             base_attr_i,
  input  logic             dir_attr_i,
  input  logic             tbl_attr_i,
  input  logic             strobe_i,
  input  logic             burst_i,
  input  logic             next_addr_i,
  input  logic             rdy_i,
  input  logic             backoff_i,
  input  logic             hold_req_i,
  output logic             hold_ack_o,
  output logic             pin_val_o,
  output logic             pin_oe_o
);
  logic rst_sync_n;
  logic sel_val;
  logic busy;
  logic ack, ack_rise;
  logic strobe_acc;
  logic val_q, val_d, val_en;
  logic oe_q, oe_d;

  wpol_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wpol_src_select u_sel (
    .real_mode_i(real_mode_i), .paging_en_i(paging_en_i),
    .acc_type_i(acc_type_i), .base_attr_i(base_attr_i),
    .dir_attr_i(dir_attr_i), .tbl_attr_i(tbl_attr_i), .sel_o(sel_val)
  );

  assign strobe_acc = strobe_i && !backoff_i && !ack;

  wpol_xfer_track #(.BURST_LEN(BURST_LEN), .SINGLE_LEN(SINGLE_LEN)) u_trk (
    .clk(clk), .rst_n(rst_sync_n), .start_i(strobe_acc), .burst_i(burst_i),
    .abort_i(backoff_i), .next_addr_i(next_addr_i), .rdy_i(rdy_i),
    .busy_o(busy)
  );

  wpol_hold_ctl u_hold (
    .clk(clk), .rst_n(rst_sync_n), .hold_req_i(hold_req_i), .busy_i(busy),
    .strobe_i(strobe_i), .ack_o(ack), .ack_rise_o(ack_rise)
  );

  always_comb begin
    val_en = strobe_acc;
    val_d  = sel_val;
    oe_d   = oe_q;
    if (backoff_i || ack_rise) oe_d = 1'b0;
    else if (strobe_acc)       oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      val_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= oe_d;
      if (val_en) val_q <= val_d;
    end
  end

  assign pin_val_o  = val_q;
  assign pin_oe_o   = oe_q;
  assign hold_ack_o = ack;

  // R1: no paging means writeback
  p_wb_forced_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_i && !backoff_i && !hold_ack_o && (real_mode_i || !paging_en_i))
      |=> !pin_val_o);

  // R5: the value only moves at an accepted strobe
  p_hold_value_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(strobe_i && !backoff_i && !hold_ack_o) |=> $stable(pin_val_o));

  // R6: backoff floats the pin
  p_float_backoff_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    backoff_i |=> !pin_oe_o);

  // R7: the pin is floated on the edge acknowledge rises
  p_float_ack_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hold_ack_o) |-> !pin_oe_o);
endmodule

// File: tb/page_wpol_driver_tb_top.sv
module page_wpol_driver_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic real_m = 0, pg = 0, strobe = 0, burst = 0, na = 0, rdy = 0;
  logic boff = 0, hreq = 0, a_b = 0, a_d = 0, a_t = 0;
  logic [2:0] acc = 3'd0;
  logic ack, val, oe;

  int checks = 0, fails = 0, cyc = 0;

  // model state
  logic m_oe = 0, m_val = 0, m_busy = 0, m_ack = 0;
  int   m_cnt = 0;
  string m_tag = "R9";

  always #4 clk = ~clk;

  page_wpol_driver dut_i (
    .clk(clk), .rst_n(rst_n), .real_mode_i(real_m), .paging_en_i(pg),
    .acc_type_i(acc), .base_attr_i(a_b), .dir_attr_i(a_d), .tbl_attr_i(a_t),
    .strobe_i(strobe), .burst_i(burst), .next_addr_i(na), .rdy_i(rdy),
    .backoff_i(boff), .hold_req_i(hreq), .hold_ack_o(ack),
    .pin_val_o(val), .pin_oe_o(oe)
  );

  function automatic logic exp_sel(logic rm, logic p, logic [2:0] a,
                                   logic b, logic d, logic t);
    if (rm || !p) return 1'b0;
    if (a == 3'd3 || a == 3'd4) return d;
    if (a == 3'd5) return t;
    return b;
  endfunction

  function automatic string sel_tag(logic rm, logic p, logic [2:0] a);
    if (rm || !p) return "R1";
    if (a == 3'd3 || a == 3'd4) return "R3";
    if (a == 3'd5) return "R4";
    return "R2";
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one clock: update model from the driven inputs, then compare
  task automatic step();
    logic acc_ok, ack_n, rise, n_oe, n_busy;
    int n_cnt;
    string oe_tag, ack_tag;
    @(posedge clk);
    cyc++;
    acc_ok = strobe && !boff && !m_ack;
    ack_n  = hreq && (m_ack || (!m_busy && !strobe));
    rise   = ack_n && !m_ack;
    ack_tag = m_busy ? "R8" : "R7";
    n_oe = m_oe; oe_tag = "R5";
    if (boff) begin n_oe = 0; oe_tag = "R6"; end
    else if (rise) begin n_oe = 0; oe_tag = "R7"; end
    else if (acc_ok) n_oe = 1;
    if (acc_ok) begin
      m_val = exp_sel(real_m, pg, acc, a_b, a_d, a_t);
      m_tag = sel_tag(real_m, pg, acc);
    end else if (!boff) m_tag = "R5";
    n_busy = m_busy; n_cnt = m_cnt;
    if (boff) begin n_busy = 0; n_cnt = 0; end
    else if (acc_ok) begin n_busy = 1; n_cnt = burst ? 4 : 1; end
    else if (m_busy) begin
      if (na || (rdy && m_cnt == 1)) begin n_busy = 0; n_cnt = 0; end
      else if (rdy) n_cnt = m_cnt - 1;
    end
    m_oe = n_oe; m_busy = n_busy; m_cnt = n_cnt; m_ack = ack_n;
    #1;
    chk(ack_tag, "hold_ack", ack, m_ack);
    chk(oe_tag, "pin_oe", oe, m_oe);
    if (m_oe) chk(m_tag, "pin_val", val, m_val);
  endtask

  task automatic idle();
    strobe = 0; na = 0; rdy = 0; boff = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset oe", oe, 1'b0);
    chk("R9", "reset val", val, 1'b0);
    chk("R9", "reset ack", ack, 1'b0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R9", "post-reset oe", oe, 1'b0);

    // R1..R4 directed: every access code, paging on and off
    for (int m = 0; m < 3; m++) begin
      for (int a = 0; a < 8; a++) begin
        real_m = (m == 2); pg = (m != 0); acc = a[2:0];
        a_b = a[0]; a_d = ~a[0]; a_t = a[1];
        strobe = 1; burst = 0; step();
        strobe = 0; a_b = ~a_b; a_d = ~a_d; a_t = ~a_t; acc = 3'd7 - acc;
        rdy = 1; step(); rdy = 0; step();
      end
    end

    // R8: hold during a burst waits for the 4th burst-ready
    real_m = 0; pg = 1; acc = 3'd5; a_t = 1;
    strobe = 1; burst = 1; step(); strobe = 0;
    hreq = 1;
    for (int k = 0; k < 4; k++) begin
      step(); step();
      chk("R8", "no ack before last rdy", ack, 1'b0);
      rdy = 1; step(); rdy = 0;
    end
    step();
    chk("R8", "ack after 4th rdy", ack, 1'b1);
    chk("R7", "floated under hold", oe, 1'b0);
    strobe = 1; step(); strobe = 0;
    chk("R7", "strobe ignored under hold", oe, 1'b0);
    hreq = 0; step(); step();
    chk("R7", "ack drops", ack, 1'b0);

    // R8: next-address closes a burst early
    strobe = 1; burst = 1; step(); strobe = 0; hreq = 1;
    step(); na = 1; step(); na = 0; step();
    chk("R8", "ack after next-address", ack, 1'b1);
    hreq = 0; step(); step();

    // R6: backoff mid-cycle floats and closes
    strobe = 1; burst = 1; step(); strobe = 0;
    boff = 1; step(); boff = 0;
    chk("R6", "floated on backoff", oe, 1'b0);
    hreq = 1; step(); step();
    chk("R6", "backoff closed cycle", ack, 1'b1);
    hreq = 0; step(); step();

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      strobe = ($urandom_range(0, 5) == 0);
      burst  = $urandom_range(0, 1);
      na     = ($urandom_range(0, 9) == 0);
      rdy    = ($urandom_range(0, 2) == 0);
      boff   = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 19) == 0) hreq = ~hreq;
      real_m = ($urandom_range(0, 7) == 0);
      pg     = ($urandom_range(0, 5) != 0);
      acc    = 3'($urandom_range(0, 7));
      a_b = 1'($urandom); a_d = 1'($urandom); a_t = 1'($urandom);
      step();
    end
    idle(); hreq = 0;
    repeat (3) step();
    finish_run();
  end
endmodule